// File: doc/BRIEF.md
# Wide System Timer with Slice Compare

This block keeps a single free-running 56-bit count for chip-wide timekeeping. The count starts on its own once power-on reset is released. It advances by one on every clock while the timer runs. Software reads the count through a small register bus. The bus offers several 32-bit windows, each taken from the count at a larger bit offset, so one read gives either fine resolution or long range. A read of the lowest window also stores the upper bits of that same count in a capture register. A second read can then rebuild the full 56-bit value without a carry slipping in between the two reads.

Two compare channels each watch a chosen slice of the count. A slice is set by a start offset and a length. When the count steps into a value whose slice equals the masked compare value, the channel sets a sticky flag and drives a one-cycle service-request pulse. A clock-control register can stop the timer outright, or halt it only while a debug request is asserted. A separate application-reset input clears the timer state unless the keep bit in clock control is set. The count wraps from all ones to zero as part of ordinary counting.

Reads return data one clock after the read strobe. Writes take effect at the clock edge where the strobe is sampled.

Top module: `wide_sys_timer`

## Requirements
- R1: After power-on reset (rst_n low) every readable register reads zero, srq is zero and clock control is zero, which means running. The count then advances with no write needed.
- R2: While running, the count grows by exactly one per clock. It wraps from all ones to zero with no other effect. Window k (address k, k from 0 to N_WIN-1, N_WIN = (CNT_W-DATA_W)/WIN_STEP+1) returns count bits starting at bit k*WIN_STEP, filled with zero above the top bit.
- R3: A read of address 0 loads count bits [CNT_W-1:DATA_W] into the capture register at address N_WIN (read zero-extended). The capture comes from the same count that the read returns. It holds that value until the next read of address 0.
- R4: bus_rdata shows the addressed register one clock after bus_rd is sampled and keeps it until the next read. An unmapped address reads zero, and a read in the same cycle as a write returns the old value.
- R5: The clock-control register sits at address N_WIN+1. Bit 0 set freezes the count. Bit 1 set freezes the count while dbg_req is high. All registers stay readable while the count is frozen.
- R6: Compare value n sits at address N_WIN+2+n. Compare config n sits at address N_WIN+2+N_CMP+n: start offset in bits [OFF_W-1:0], length minus one in the next LEN_W bits, enable in bit OFF_W+LEN_W. An enabled channel fires on the edge where the count advances into a value whose masked slice equals the masked compare value, having not matched before. That edge sets flag n and raises srq[n] for exactly that one cycle.
- R7: The flags register sits at address N_WIN+2+2*N_CMP, with bit n for channel n. Writing 1 to a bit clears it, and writing 0 has no effect. If a new hit and a clear land in the same cycle, the hit wins. A disabled channel never sets its flag.
- R8: With clock-control bit 2 clear, app_rst zeroes the count, the capture register, the compare values and the compare configs at the next edge. This clear takes priority over an advance, a capture or a write in the same cycle.
- R9: With clock-control bit 2 set, app_rst has no effect. app_rst never changes clock control or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| app_rst | input | 1 | Synchronous application reset request |
| dbg_req | input | 1 | Debug halt request, honoured when clock-control bit 1 is set |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_rd |
| srq | output | N_CMP | One-cycle service-request pulse per compare channel |

## Verification
The tightest overlap is a compare hit and a software write-1-to-clear of the same flag landing on one clock edge. The bench sets up a channel that matches on every odd count and then writes clears to the flag register on consecutive cycles, so some writes fall on hit edges and some do not. A reference model in the bench judges each edge, where the hit must leave the flag set. The bench also fires an application reset in the same cycle as a capture read and as a compare write, and checks that the clear wins.

// File: rtl/wst_pkg.sv
package wst_pkg;

   // clock-control bit positions
   localparam int CTL_STOP    = 0;
   localparam int CTL_HALT_EN = 1;
   localparam int CTL_KEEP    = 2;
   localparam int CTL_W       = 3;

   // mask with the low (n+1) bits set
   function automatic logic [63:0] len_mask(input int unsigned n);
      return (64'd2 << n) - 64'd1;
   endfunction

endpackage

// File: rtl/wst_counter.sv
module wst_counter #(
   parameter int CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_inc
);

   assign cnt_inc = cnt + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (adv)  cnt <= cnt_inc;
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> ((cnt - $past(cnt)) == CNT_W'(1)));

   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/wst_cmp_chan.sv
module wst_cmp_chan #(
   parameter int CNT_W  = 56,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 6,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  cnt_inc,
   input  logic              adv,
   input  logic              clr,
   input  logic              en,
   input  logic [OFF_W-1:0]  off,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] val,
   input  logic              flag_clr,
   output logic              flag,
   output logic              srq
);

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] sl_now;
   logic [DATA_W-1:0] sl_nxt;
   logic              hit_now;
   logic              hit_nxt;
   logic              fire;

   assign mask    = DATA_W'(wst_pkg::len_mask(32'(len)));
   assign sl_now  = DATA_W'(cnt >> off);
   assign sl_nxt  = DATA_W'(cnt_inc >> off);
   assign hit_now = ((sl_now ^ val) & mask) == '0;
   assign hit_nxt = ((sl_nxt ^ val) & mask) == '0;
   // fire only when the advancing count enters the match
   assign fire    = en & adv & ~clr & hit_nxt & ~hit_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srq  <= 1'b0;
         flag <= 1'b0;
      end else begin
         srq  <= fire;
         flag <= fire | (flag & ~flag_clr);
      end
   end

   p_srq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      srq |-> flag);

   p_srq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srq |-> $past(en));

   p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(flag_clr));

endmodule

// File: rtl/wst_regs.sv
module wst_regs #(
   parameter int CNT_W    = 56,
   parameter int DATA_W   = 32,
   parameter int WIN_STEP = 4,
   parameter int N_CMP    = 2,
   parameter int ADDR_W   = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         app_rst,
   input  logic                         dbg_req,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [CNT_W-1:0]             cnt,
   input  logic [N_CMP-1:0]             flags,
   output logic                         adv,
   output logic                         clr,
   output logic [N_CMP-1:0][DATA_W-1:0] cmp_val,
   output logic [N_CMP-1:0][$clog2(CNT_W)+$clog2(DATA_W):0] cmp_cfg,
   output logic [N_CMP-1:0]             flag_clr
);
   import wst_pkg::*;

   localparam int OFF_W   = $clog2(CNT_W);
   localparam int LEN_W   = $clog2(DATA_W);
   localparam int CFG_W   = OFF_W + LEN_W + 1;
   localparam int CAP_W   = CNT_W - DATA_W;
   localparam int N_WIN   = CAP_W / WIN_STEP + 1;
   localparam int A_VAL_I = N_WIN + 2;
   localparam int A_CFG_I = A_VAL_I + N_CMP;
   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(N_WIN);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(N_WIN + 1);
   localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(A_CFG_I + N_CMP);

   logic [CTL_W-1:0]             ctl;
   logic [CAP_W-1:0]             cap;
   logic [N_WIN-1:0][DATA_W-1:0] win;
   logic [DATA_W-1:0]            rd_mux;
   logic                         rd_low;

   for (genvar k = 0; k < N_WIN; k++) begin : g_win
      assign win[k] = DATA_W'(cnt >> (k * WIN_STEP));
   end

   assign adv    = ~ctl[CTL_STOP] & ~(ctl[CTL_HALT_EN] & dbg_req);
   assign clr    = app_rst & ~ctl[CTL_KEEP];
   assign rd_low = bus_rd && (bus_addr == '0);

   for (genvar c = 0; c < N_CMP; c++) begin : g_w1c
      assign flag_clr[c] = bus_wr && (bus_addr == A_FLG) && bus_wdata[c];
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < N_WIN; k++)
         if (bus_addr == ADDR_W'(k)) rd_mux = win[k];
      if (bus_addr == A_CAP) rd_mux = DATA_W'(cap);
      if (bus_addr == A_CTL) rd_mux = DATA_W'(ctl);
      for (int c = 0; c < N_CMP; c++) begin
         if (bus_addr == ADDR_W'(A_VAL_I + c)) rd_mux = cmp_val[c];
         if (bus_addr == ADDR_W'(A_CFG_I + c)) rd_mux = DATA_W'(cmp_cfg[c]);
      end
      if (bus_addr == A_FLG) rd_mux = DATA_W'(flags);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         cap       <= '0;
         cmp_val   <= '0;
         cmp_cfg   <= '0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && bus_addr == A_CTL) ctl <= bus_wdata[CTL_W-1:0];
         if (clr) begin
            cap     <= '0;
            cmp_val <= '0;
            cmp_cfg <= '0;
         end else begin
            if (rd_low) cap <= cnt[CNT_W-1:DATA_W];
            for (int c = 0; c < N_CMP; c++) begin
               if (bus_wr && bus_addr == ADDR_W'(A_VAL_I + c)) cmp_val[c] <= bus_wdata;
               if (bus_wr && bus_addr == ADDR_W'(A_CFG_I + c)) cmp_cfg[c] <= bus_wdata[CFG_W-1:0];
            end
         end
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_low && !clr) |=> (cap == $past(cnt[CNT_W-1:DATA_W])));

   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   p_app_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cap == '0 && cmp_val == '0 && cmp_cfg == '0));

   p_ctl_only_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_CTL) |=> $stable(ctl));

endmodule

// File: rtl/wide_sys_timer.sv
module wide_sys_timer #(
   parameter int CNT_W    = 56,
   parameter int DATA_W   = 32,
   parameter int WIN_STEP = 4,
   parameter int N_CMP    = 2,
   parameter int ADDR_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              app_rst,
   input  logic              dbg_req,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CMP-1:0]  srq
);

   localparam int OFF_W = $clog2(CNT_W);
   localparam int LEN_W = $clog2(DATA_W);
   localparam int CFG_W = OFF_W + LEN_W + 1;
   localparam int CAP_W = CNT_W - DATA_W;
   localparam int N_WIN = (CAP_W > 0) ? CAP_W / WIN_STEP + 1 : 1;
   localparam int LAST_A = N_WIN + 2 + 2 * N_CMP;

   // elaboration-time parameter checks
   if (CNT_W <= DATA_W) begin : g_chk_width
      $error("count must be wider than the data bus");
   end
   if (WIN_STEP < 1 || (CAP_W % WIN_STEP) != 0) begin : g_chk_step
      $error("window step must divide the count/data width difference");
   end
   if (CAP_W > DATA_W) begin : g_chk_cap
      $error("capture register does not fit one data word");
   end
   if (CFG_W > DATA_W) begin : g_chk_cfg
      $error("compare config does not fit one data word");
   end
   if (N_CMP < 1 || N_CMP > DATA_W) begin : g_chk_ncmp
      $error("compare channel count out of range");
   end
   if (LAST_A >= (1 << ADDR_W)) begin : g_chk_addr
      $error("address width too small for the register map");
   end

   logic [CNT_W-1:0]             cnt;
   logic [CNT_W-1:0]             cnt_inc;
   logic                         adv;
   logic                         clr;
   logic [N_CMP-1:0][DATA_W-1:0] cmp_val;
   logic [N_CMP-1:0][CFG_W-1:0]  cmp_cfg;
   logic [N_CMP-1:0]             flag_clr;
   logic [N_CMP-1:0]             flags;

   wst_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .clr     (clr),
      .cnt     (cnt),
      .cnt_inc (cnt_inc)
   );

   wst_regs #(
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .WIN_STEP (WIN_STEP),
      .N_CMP    (N_CMP),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .app_rst   (app_rst),
      .dbg_req   (dbg_req),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt),
      .flags     (flags),
      .adv       (adv),
      .clr       (clr),
      .cmp_val   (cmp_val),
      .cmp_cfg   (cmp_cfg),
      .flag_clr  (flag_clr)
   );

   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      wst_cmp_chan #(
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W),
         .OFF_W  (OFF_W),
         .LEN_W  (LEN_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt      (cnt),
         .cnt_inc  (cnt_inc),
         .adv      (adv),
         .clr      (clr),
         .en       (cmp_cfg[c][CFG_W-1]),
         .off      (cmp_cfg[c][OFF_W-1:0]),
         .len      (cmp_cfg[c][OFF_W+LEN_W-1:OFF_W]),
         .val      (cmp_val[c]),
         .flag_clr (flag_clr[c]),
         .flag     (flags[c]),
         .srq      (srq[c])
      );
   end

   p_srq_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (srq == '0));

endmodule

// File: tb/wide_sys_timer_tb.sv
module wide_sys_timer_tb;
   localparam int CNT_W    = 14;
   localparam int DATA_W   = 8;
   localparam int WIN_STEP = 2;
   localparam int N_CMP    = 2;
   localparam int ADDR_W   = 5;
   localparam int OFF_W    = $clog2(CNT_W);
   localparam int LEN_W    = $clog2(DATA_W);
   localparam int CFG_W    = OFF_W + LEN_W + 1;
   localparam int N_WIN    = (CNT_W - DATA_W) / WIN_STEP + 1;
   localparam int A_CAP    = N_WIN;
   localparam int A_CTL    = N_WIN + 1;
   localparam int A_VAL    = N_WIN + 2;
   localparam int A_CFG    = A_VAL + N_CMP;
   localparam int A_FLG    = A_CFG + N_CMP;
   localparam longint CMASK = (64'd1 << CNT_W) - 1;
   localparam longint DMASK = (64'd1 << DATA_W) - 1;

   logic              clk;
   logic              rst_n;
   logic              app_rst;
   logic              dbg_req;
   logic              bus_wr;
   logic              bus_rd;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic [N_CMP-1:0]  srq;

   wide_sys_timer #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .WIN_STEP(WIN_STEP),
      .N_CMP(N_CMP), .ADDR_W(ADDR_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .app_rst(app_rst), .dbg_req(dbg_req),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .srq(srq)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int     checks = 0;
   int     errors = 0;
   bit     done   = 0;
   bit     m_live = 0;
   string  scen   = "";

   // reference model state
   longint m_cnt, m_cap, m_ctl, m_flags, m_srq, m_rdata;
   longint m_val [N_CMP];
   longint m_cfg [N_CMP];
   string  m_tag = "R1";

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_hit(int ch, longint c);
      longint off, len, msk, sl;
      off = m_cfg[ch] & ((64'd1 << OFF_W) - 1);
      len = (m_cfg[ch] >> OFF_W) & ((64'd1 << LEN_W) - 1);
      msk = ((64'd2 << len) - 1) & DMASK;
      sl  = (c >> off) & DMASK;
      return ((sl ^ m_val[ch]) & msk) == 0;
   endfunction

   function automatic longint m_read(int a);
      if (a < N_WIN) return (m_cnt >> (a * WIN_STEP)) & DMASK;
      if (a == A_CAP) return m_cap;
      if (a == A_CTL) return m_ctl;
      for (int c = 0; c < N_CMP; c++) begin
         if (a == A_VAL + c) return m_val[c];
         if (a == A_CFG + c) return m_cfg[c];
      end
      if (a == A_FLG) return m_flags;
      return 0;
   endfunction

   function automatic string tag_of(int a);
      if (a == 0) return "R3";
      if (a < N_WIN) return "R2";
      if (a == A_CAP) return "R3";
      if (a == A_CTL) return "R5";
      if (a < A_FLG) return "R6";
      if (a == A_FLG) return "R7";
      return "R4";
   endfunction

   // cycle model, evaluated on each rising edge from the sampled inputs
   always @(posedge clk) begin
      bit     adv, clr;
      longint inc, nsrq, nflg;
      if (!rst_n) begin
         m_cnt = 0; m_cap = 0; m_ctl = 0; m_flags = 0; m_srq = 0; m_rdata = 0;
         for (int c = 0; c < N_CMP; c++) begin m_val[c] = 0; m_cfg[c] = 0; end
         m_live = 1;
      end else begin
         adv  = !m_ctl[0] && !(m_ctl[1] && dbg_req);
         clr  = app_rst && !m_ctl[2];
         inc  = (m_cnt + 1) & CMASK;
         nsrq = 0;
         for (int c = 0; c < N_CMP; c++)
            if (m_cfg[c][CFG_W-1] && adv && !clr && m_hit(c, inc) && !m_hit(c, m_cnt))
               nsrq |= (64'd1 << c);
         nflg = m_flags;
         if (bus_wr && bus_addr == A_FLG) nflg &= ~longint'(bus_wdata);
         nflg = (nflg | nsrq) & ((64'd1 << N_CMP) - 1);
         if (bus_rd) begin
            m_rdata = m_read(int'(bus_addr));
            m_tag   = tag_of(int'(bus_addr));
         end
         if (clr) begin
            m_cap = 0;
            for (int c = 0; c < N_CMP; c++) begin m_val[c] = 0; m_cfg[c] = 0; end
         end else begin
            if (bus_rd && bus_addr == 0) m_cap = m_cnt >> DATA_W;
            for (int c = 0; c < N_CMP; c++) begin
               if (bus_wr && bus_addr == A_VAL + c) m_val[c] = bus_wdata;
               if (bus_wr && bus_addr == A_CFG + c) m_cfg[c] = bus_wdata & ((64'd1 << CFG_W) - 1);
            end
         end
         if (bus_wr && bus_addr == A_CTL) m_ctl = bus_wdata & 7;
         if (clr) m_cnt = 0;
         else if (adv) m_cnt = inc;
         m_srq   = nsrq;
         m_flags = nflg;
      end
   end

   // compare the design against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (m_live && !done) begin
         chk((scen != "") ? scen : m_tag, longint'(bus_rdata), m_rdata);
         chk((scen != "") ? scen : "R6", longint'(srq), m_srq);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(int a);
      bus_rd = 1'b1; bus_addr = ADDR_W'(a);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(int a, int d);
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   initial begin
      longint v1;
      rst_n = 1'b0; app_rst = 1'b0; dbg_req = 1'b0;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1", longint'(srq), 0);
      chk("R1", longint'(bus_rdata), 0);
      rst_n = 1'b1;

      // R1: reset contents, automatic start; R4: unmapped addresses
      rd(A_CTL); chk("R1", longint'(bus_rdata), 0);
      for (int a = 1; a <= A_FLG + 2; a++) rd(a);
      rd(0); v1 = bus_rdata; idle(5); rd(0);
      chk("R1", (longint'(bus_rdata) - v1) & DMASK, 6);

      // R2: one step per clock
      rd(0); v1 = bus_rdata; rd(0);
      chk("R2", (longint'(bus_rdata) - v1) & DMASK, 1);

      // R4: read and write in the same cycle returns the old value
      bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(A_VAL); bus_wdata = 8'h5A;
      @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
      chk("R4", longint'(bus_rdata), 0);

      // R6: full-width compare on channel 0, two-bit slice at offset 4 on channel 1
      wr(A_VAL, 8'h60); wr(A_CFG, 8'hF0);
      wr(A_VAL + 1, 2); wr(A_CFG + 1, 8'h94);
      idle(100);
      rd(A_FLG); chk("R6", longint'(bus_rdata) & 1, 1);

      // R7: clear, then a disabled channel stays quiet
      wr(A_CFG + 1, 8'h14); wr(A_FLG, 3); idle(80);
      rd(A_FLG); chk("R7", longint'(bus_rdata) & 2, 0);

      // R7: hit and write-1-to-clear colliding on the same edge
      wr(A_VAL + 1, 1); wr(A_CFG + 1, 8'h80);
      for (int i = 0; i < 9; i++) wr(A_FLG, 2);
      idle(3); wr(A_CFG + 1, 0); rd(A_FLG);

      // R5: stop bit, then debug halt
      wr(A_CTL, 1); rd(0); v1 = bus_rdata; idle(10); rd(0);
      chk("R5", longint'(bus_rdata), v1);
      rd(A_CFG); chk("R5", longint'(bus_rdata), 8'hF0);
      wr(A_CTL, 2); dbg_req = 1'b1; rd(0); v1 = bus_rdata; idle(5); rd(0);
      chk("R5", longint'(bus_rdata), v1);
      dbg_req = 1'b0; rd(0); v1 = bus_rdata; idle(3); rd(0);
      chk("R5", (longint'(bus_rdata) - v1) & DMASK, 4);
      wr(A_CTL, 0);

      // R8: application reset colliding with a capture read
      idle(40);
      scen = "R8";
      app_rst = 1'b1; rd(0); app_rst = 1'b0;
      rd(0);     chk("R8", longint'(bus_rdata), 0);
      rd(A_CAP); chk("R8", longint'(bus_rdata), 0);
      rd(A_CFG); chk("R8", longint'(bus_rdata), 0);
      rd(A_VAL); chk("R8", longint'(bus_rdata), 0);
      // R8: clear beats a write in the same cycle
      app_rst = 1'b1; wr(A_VAL + 1, 8'h33); app_rst = 1'b0;
      rd(A_VAL + 1); chk("R8", longint'(bus_rdata), 0);

      // R9: keep bit set, application reset ignored
      scen = "R9";
      wr(A_CTL, 4); rd(0); v1 = bus_rdata;
      app_rst = 1'b1; idle(1); app_rst = 1'b0; rd(0);
      chk("R9", (longint'(bus_rdata) - v1) & DMASK, 2);
      rd(A_CTL); chk("R9", longint'(bus_rdata), 4);
      wr(A_CTL, 0); rd(A_FLG);
      scen = "";

      // R2, R3: long run across upper bits and through the wrap
      wr(A_VAL, 0);     wr(A_CFG, 8'hF0);
      wr(A_VAL + 1, 5); wr(A_CFG + 1, 8'hBA);
      for (int i = 0; i < 72; i++) begin
         idle(230);
         rd(0);
         rd(A_CAP);
         rd(N_WIN - 1);
      end
      rd(A_FLG);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule